// File: doc/BRIEF.md
# Configuration Memory Test Access Port

This block is the IEEE 1149.1 test access port of a configuration-memory device. A serial test clock drives it, along with a mode-select line and a serial data input, and an optional active-low asynchronous reset. It returns a serial data output, together with an enable for that output. Its 16-bit instruction register does not capture a fixed pattern. At each instruction capture it loads a snapshot of live device status: the outcome of the last in-system configuration, the outcome of the last erase or program, erase/program activity, in-system configuration mode, and whether the selected revision is fully programmed. A tester reads that snapshot in the same scan that loads the next instruction.

The decoder recognises the mandatory, optional and device-specific opcodes. It selects one of three internal data paths: a 1-bit bypass register, a 32-bit identification register and a 32-bit user code register. It can also route the data scan to an external boundary chain, which is represented here only by a serial return input and select outputs. The configuration opcode produces exactly one low pulse, one clock long, on an active-low configuration-start output. A revision-reset strobe fires alongside it. All control and status pins are plain levels; the block has no streaming interface.

Top module: `cfg_tap`

## Requirements
- R1: During instruction capture the register loads a pattern whose bits 15:9 are 0 and bits 1:0 are 2'b01, and this pattern is the first value shifted out.
- R2: The capture pattern reflects the status inputs. Bits 8:7 are 2'b01 when `isc_fail` is 1 and 2'b10 otherwise. Bits 6:5 are 2'b01 when `prog_fail` is 1 and 2'b10 otherwise. Bit 4 is the inverse of `prog_busy`, bit 3 is `isc_active` and bit 2 is `rev_done`.
- R3: Instruction and data registers shift least significant bit first on the rising clock edge. `tap_dout` changes on the falling edge, and `tap_dout_en` is high only in the two shift states. A newly shifted instruction takes effect only on leaving the instruction update state.
- R4: The reset state loads the identification opcode 16'h00FE. The reset state is entered by `tap_rst_n` low or by five rising edges with `tap_mode` high.
- R5: Opcode 16'h00FE shifts out the 32-bit `ID_CODE` and opcode 16'h00FD shifts out the 32-bit `USER_CODE`, both LSB first. Bit 0 of `ID_CODE` is 1.
- R6: Opcode 16'hFFFF, every opcode not listed in these requirements, and the opcodes 16'h00FA, 16'h00FC and 16'h00EE each select a 1-bit register that captures 0. A data scan of n bits therefore returns 0 followed by the first n-1 input bits.
- R7: Opcodes 16'h0001 (sample) and 16'h0000 (external test) raise `bsr_sel` and route `bsr_so` to `tap_dout` during a data shift. `bsr_drive` is high for 16'h0000 and 16'h00FA (clamp) and low otherwise.
- R8: Opcode 16'h00FC raises `hiz_req` while it is the current instruction, and `hiz_req` is low for every other instruction.
- R9: After an instruction update that loads 16'h00EE, the first rising edge in the idle state drives `cfg_start_n` low and `rev_rst` high for exactly one clock. The pulse does not recur until another update loads 16'h00EE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tap_clk | input | 1 | Test clock |
| tap_rst_n | input | 1 | Asynchronous active-low test reset |
| tap_mode | input | 1 | State machine mode select |
| tap_din | input | 1 | Serial data in |
| tap_dout | output | 1 | Serial data out, updated on the falling edge |
| tap_dout_en | output | 1 | High while the serial output is valid |
| isc_fail | input | 1 | Last in-system configuration failed |
| prog_fail | input | 1 | Last erase/program failed |
| prog_busy | input | 1 | Erase/program in progress |
| isc_active | input | 1 | Device in in-system configuration mode |
| rev_done | input | 1 | Selected revision fully programmed |
| bsr_so | input | 1 | Serial return from the external boundary chain |
| bsr_sel | output | 1 | Boundary chain is the selected data path |
| bsr_drive | output | 1 | Pins driven from the boundary chain |
| hiz_req | output | 1 | Request all outputs to high impedance |
| cfg_start_n | output | 1 | Active-low configuration start pulse |
| rev_rst | output | 1 | Revision-selection reset strobe |

## Verification
The hardest condition to bring about is the one-shot behaviour of the configuration pulse. It needs an instruction update that loads 16'h00EE and then several idle cycles. It also needs a later data scan that passes through idle again while the same instruction is current, and only then a fresh update. The bench walks through that sequence and counts low cycles on `cfg_start_n` in each window, so that a pulse that repeats or lasts too long is caught. Mode-driven reset is reached from a non-default instruction by holding `tap_mode` high for five edges, and a following data scan confirms that the identification code is back.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;

  localparam int unsigned IR_W = 16;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    OP_BYPASS, OP_SAMPLE, OP_EXTEST, OP_CLAMP,
    OP_HIGHZ, OP_IDCODE, OP_USERCODE, OP_CONFIG
  } op_e;

  localparam logic [IR_W-1:0] OPC_BYPASS   = 16'hFFFF;
  localparam logic [IR_W-1:0] OPC_SAMPLE   = 16'h0001;
  localparam logic [IR_W-1:0] OPC_EXTEST   = 16'h0000;
  localparam logic [IR_W-1:0] OPC_CLAMP    = 16'h00FA;
  localparam logic [IR_W-1:0] OPC_HIGHZ    = 16'h00FC;
  localparam logic [IR_W-1:0] OPC_IDCODE   = 16'h00FE;
  localparam logic [IR_W-1:0] OPC_USERCODE = 16'h00FD;
  localparam logic [IR_W-1:0] OPC_CONFIG   = 16'h00EE;

  typedef struct packed {
    logic isc_fail;
    logic prog_fail;
    logic prog_busy;
    logic isc_active;
    logic rev_done;
  } dev_status_t;

  function automatic op_e decode_op(input logic [IR_W-1:0] code);
    case (code)
      OPC_SAMPLE:   return OP_SAMPLE;
      OPC_EXTEST:   return OP_EXTEST;
      OPC_CLAMP:    return OP_CLAMP;
      OPC_HIGHZ:    return OP_HIGHZ;
      OPC_IDCODE:   return OP_IDCODE;
      OPC_USERCODE: return OP_USERCODE;
      OPC_CONFIG:   return OP_CONFIG;
      default:      return OP_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/cfg_tap_fsm.sv
module cfg_tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic       tap_clk,
  input  logic       tap_rst_n,
  input  logic       tap_mode,
  output tap_state_e st
);

  tap_state_e st_nx;
  logic [2:0] ones_run;

  always_comb begin
    case (st)
      TS_RESET:  st_nx = tap_mode ? TS_RESET  : TS_IDLE;
      TS_IDLE:   st_nx = tap_mode ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: st_nx = tap_mode ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: st_nx = tap_mode ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: st_nx = tap_mode ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: st_nx = tap_mode ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: st_nx = tap_mode ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: st_nx = tap_mode ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: st_nx = tap_mode ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: st_nx = tap_mode ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: st_nx = tap_mode ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: st_nx = tap_mode ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: st_nx = tap_mode ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: st_nx = tap_mode ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: st_nx = tap_mode ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: st_nx = tap_mode ? TS_SEL_DR : TS_IDLE;
      default:   st_nx = TS_RESET;
    endcase
  end

  always_ff @(posedge tap_clk or negedge tap_rst_n) begin
    if (!tap_rst_n) st <= TS_RESET;
    else            st <= st_nx;
  end

  // run of consecutive high mode samples, saturating at five
  always_ff @(posedge tap_clk or negedge tap_rst_n) begin
    if (!tap_rst_n)        ones_run <= 3'd0;
    else if (!tap_mode)    ones_run <= 3'd0;
    else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    (ones_run == 3'd5) |-> (st == TS_RESET)); // R4

endmodule

// File: rtl/cfg_tap_ir.sv
module cfg_tap_ir
  import cfg_tap_pkg::*;
(
  input  logic        tap_clk,
  input  logic        tap_rst_n,
  input  tap_state_e  st,
  input  logic        tap_din,
  input  dev_status_t stat,
  output logic        ir_so,
  output op_e         cur_op,
  output logic        upd_cfg
);

  localparam int unsigned RSV_W = IR_W - 9;

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] cap_word;

  always_comb begin
    cap_word = {{RSV_W{1'b0}},
                (stat.isc_fail  ? 2'b01 : 2'b10),
                (stat.prog_fail ? 2'b01 : 2'b10),
                ~stat.prog_busy,
                stat.isc_active,
                stat.rev_done,
                2'b01};
  end

  always_ff @(posedge tap_clk or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      ir_sr <= '0;
      ir_q  <= OPC_IDCODE;
    end else begin
      case (st)
        TS_RESET:  ir_q  <= OPC_IDCODE;
        TS_CAP_IR: ir_sr <= cap_word;
        TS_SHF_IR: ir_sr <= {tap_din, ir_sr[IR_W-1:1]};
        TS_UPD_IR: ir_q  <= ir_sr;
        default: ;
      endcase
    end
  end

  assign ir_so   = ir_sr[0];
  assign cur_op  = decode_op(ir_q);
  assign upd_cfg = (st == TS_UPD_IR) && (decode_op(ir_sr) == OP_CONFIG);

  AST_CAPTURE_FIXED_BITS: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    (st == TS_CAP_IR) |=> (ir_sr[1:0] == 2'b01) && (ir_sr[IR_W-1:9] == '0)); // R1

  AST_IR_CHANGES_ON_UPDATE: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    !$stable(ir_q) |-> ($past(st) == TS_UPD_IR || $past(st) == TS_RESET)); // R3

  AST_RESET_LOADS_ID: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    (st == TS_RESET) |=> (ir_q == OPC_IDCODE)); // R4

endmodule

// File: rtl/cfg_tap_dr.sv
module cfg_tap_dr
  import cfg_tap_pkg::*;
#(
  parameter int unsigned DR_W      = 32,
  parameter logic [31:0] ID_CODE   = 32'h0A1C_5093,
  parameter logic [31:0] USER_CODE = 32'h5EED_C0DE
) (
  input  logic       tap_clk,
  input  logic       tap_rst_n,
  input  tap_state_e st,
  input  logic       tap_din,
  input  op_e        cur_op,
  input  logic       bsr_so,
  output logic       dr_so
);

  logic [DR_W-1:0] dr_sr;
  logic            wide_path;
  logic            chain_path;

  assign wide_path  = (cur_op == OP_IDCODE) || (cur_op == OP_USERCODE);
  assign chain_path = (cur_op == OP_SAMPLE) || (cur_op == OP_EXTEST);

  always_ff @(posedge tap_clk or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      dr_sr <= '0;
    end else if (st == TS_CAP_DR) begin
      case (cur_op)
        OP_IDCODE:   dr_sr <= ID_CODE[DR_W-1:0];
        OP_USERCODE: dr_sr <= USER_CODE[DR_W-1:0];
        default:     dr_sr <= '0;
      endcase
    end else if (st == TS_SHF_DR) begin
      if (wide_path) dr_sr    <= {tap_din, dr_sr[DR_W-1:1]};
      else           dr_sr[0] <= tap_din;
    end
  end

  assign dr_so = chain_path ? bsr_so : dr_sr[0];

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    (st == TS_CAP_DR && !wide_path) |=> (dr_sr[0] == 1'b0)); // R6

  AST_ID_CAPTURE: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    (st == TS_CAP_DR && cur_op == OP_IDCODE) |=> (dr_sr == ID_CODE[DR_W-1:0])); // R5

endmodule

// File: rtl/cfg_tap_pulse.sv
module cfg_tap_pulse
  import cfg_tap_pkg::*;
(
  input  logic       tap_clk,
  input  logic       tap_rst_n,
  input  tap_state_e st,
  input  logic       upd_cfg,
  output logic       cfg_pulse
);

  logic armed;

  always_ff @(posedge tap_clk or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      armed     <= 1'b0;
      cfg_pulse <= 1'b0;
    end else begin
      cfg_pulse <= (st == TS_IDLE) && armed;
      if (st == TS_RESET)     armed <= 1'b0;
      else if (upd_cfg)       armed <= 1'b1;
      else if (st == TS_IDLE) armed <= 1'b0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    cfg_pulse |=> !cfg_pulse); // R9

  AST_PULSE_FROM_IDLE: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    cfg_pulse |-> ($past(st) == TS_IDLE)); // R9

endmodule

// File: rtl/cfg_tap.sv
module cfg_tap
  import cfg_tap_pkg::*;
#(
  parameter int unsigned DR_W      = 32,
  parameter logic [31:0] ID_CODE   = 32'h0A1C_5093,
  parameter logic [31:0] USER_CODE = 32'h5EED_C0DE
) (
  input  logic tap_clk,
  input  logic tap_rst_n,
  input  logic tap_mode,
  input  logic tap_din,
  output logic tap_dout,
  output logic tap_dout_en,
  input  logic isc_fail,
  input  logic prog_fail,
  input  logic prog_busy,
  input  logic isc_active,
  input  logic rev_done,
  input  logic bsr_so,
  output logic bsr_sel,
  output logic bsr_drive,
  output logic hiz_req,
  output logic cfg_start_n,
  output logic rev_rst
);

  tap_state_e  st;
  dev_status_t stat;
  op_e         cur_op;
  logic        ir_so;
  logic        dr_so;
  logic        upd_cfg;
  logic        cfg_pulse;

  assign stat = '{isc_fail: isc_fail, prog_fail: prog_fail, prog_busy: prog_busy,
                  isc_active: isc_active, rev_done: rev_done};

  cfg_tap_fsm u_fsm (
    .tap_clk(tap_clk), .tap_rst_n(tap_rst_n), .tap_mode(tap_mode), .st(st)
  );

  cfg_tap_ir u_ir (
    .tap_clk(tap_clk), .tap_rst_n(tap_rst_n), .st(st), .tap_din(tap_din),
    .stat(stat), .ir_so(ir_so), .cur_op(cur_op), .upd_cfg(upd_cfg)
  );

  cfg_tap_dr #(.DR_W(DR_W), .ID_CODE(ID_CODE), .USER_CODE(USER_CODE)) u_dr (
    .tap_clk(tap_clk), .tap_rst_n(tap_rst_n), .st(st), .tap_din(tap_din),
    .cur_op(cur_op), .bsr_so(bsr_so), .dr_so(dr_so)
  );

  cfg_tap_pulse u_pulse (
    .tap_clk(tap_clk), .tap_rst_n(tap_rst_n), .st(st), .upd_cfg(upd_cfg),
    .cfg_pulse(cfg_pulse)
  );

  // serial output retimed on the falling edge
  always_ff @(negedge tap_clk or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tap_dout    <= 1'b0;
      tap_dout_en <= 1'b0;
    end else begin
      tap_dout_en <= (st == TS_SHF_IR) || (st == TS_SHF_DR);
      tap_dout    <= (st == TS_SHF_IR) ? ir_so :
                     (st == TS_SHF_DR) ? dr_so : 1'b0;
    end
  end

  assign bsr_sel     = (cur_op == OP_SAMPLE) || (cur_op == OP_EXTEST);
  assign bsr_drive   = (cur_op == OP_EXTEST) || (cur_op == OP_CLAMP);
  assign hiz_req     = (cur_op == OP_HIGHZ);
  assign cfg_start_n = ~cfg_pulse;
  assign rev_rst     = cfg_pulse;

  AST_DOUT_EN_IN_SHIFT: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    tap_dout_en |-> (st == TS_SHF_IR || st == TS_SHF_DR)); // R3

  AST_HIZ_EXCLUSIVE: assert property (@(posedge tap_clk) disable iff (!tap_rst_n)
    hiz_req |-> !bsr_sel && !bsr_drive); // R8

endmodule

// File: tb/cfg_tap_tb.sv
module cfg_tap_tb;
  import cfg_tap_pkg::*;

  localparam time         TCK_PERIOD = 20;
  localparam logic [31:0] ID_V   = 32'h0A1C_5093;
  localparam logic [31:0] USER_V = 32'h5EED_C0DE;

  logic tap_clk = 1'b0, tap_rst_n = 1'b0, tap_mode = 1'b1, tap_din = 1'b0;
  logic tap_dout, tap_dout_en;
  logic isc_fail = 0, prog_fail = 0, prog_busy = 0, isc_active = 0, rev_done = 0;
  logic bsr_so = 0;
  logic bsr_sel, bsr_drive, hiz_req, cfg_start_n, rev_rst;

  cfg_tap #(.ID_CODE(ID_V), .USER_CODE(USER_V)) u_dut (
    .tap_clk(tap_clk), .tap_rst_n(tap_rst_n), .tap_mode(tap_mode), .tap_din(tap_din),
    .tap_dout(tap_dout), .tap_dout_en(tap_dout_en),
    .isc_fail(isc_fail), .prog_fail(prog_fail), .prog_busy(prog_busy),
    .isc_active(isc_active), .rev_done(rev_done), .bsr_so(bsr_so),
    .bsr_sel(bsr_sel), .bsr_drive(bsr_drive), .hiz_req(hiz_req),
    .cfg_start_n(cfg_start_n), .rev_rst(rev_rst)
  );

  always #(TCK_PERIOD/2) tap_clk = ~tap_clk;

  typedef struct {
    logic [31:0] val;
    int          len;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: gathers serial output bits, compares each finished scan
  initial begin
    logic [31:0] got;
    int nbits;
    got = '0;
    nbits = 0;
    forever begin
      @(negedge tap_clk);
      #2;
      if (tap_dout_en) begin
        if (nbits < 32) got[nbits] = tap_dout;
        nbits++;
      end else if (nbits > 0) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R3 unexpected scan: got %h expected none", got);
        end else begin
          exp_t e;
          logic [31:0] mask;
          e = exp_q.pop_front();
          mask = (e.len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << e.len) - 32'd1);
          n_cmp++;
          if (nbits != e.len || (got & mask) !== (e.val & mask)) begin
            n_bad++;
            $display("FAIL %s: got %h (%0d bits) expected %h (%0d bits)",
                     e.tag, got & mask, nbits, e.val & mask, e.len);
          end
        end
        nbits = 0;
        got = '0;
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tap_clk);
    #1;
    tap_mode = m;
    tap_din  = d;
    @(posedge tap_clk);
    #1;
  endtask

  function automatic logic [31:0] cap_exp();
    return {16'h0, 7'h0, (isc_fail ? 2'b01 : 2'b10), (prog_fail ? 2'b01 : 2'b10),
            ~prog_busy, isc_active, rev_done, 2'b01};
  endfunction

  function automatic logic [31:0] byp_exp(input logic [31:0] din, input int len);
    logic [31:0] r;
    r = '0;
    for (int i = 1; i < len; i++) r[i] = din[i-1];
    return r;
  endfunction

  // driver: pushes expected scan output, then drives the scan from idle back to idle
  task automatic ir_scan(input logic [15:0] opc, input string tag);
    exp_q.push_back('{val: cap_exp(), len: 16, tag: tag});
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 16; i++) step(i == 15, opc[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int len, input logic [31:0] din,
                         input logic [31:0] exp, input string tag);
    exp_q.push_back('{val: exp, len: len, tag: tag});
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < len; i++) step(i == len - 1, din[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int lows;
    repeat (2) @(posedge tap_clk);
    #3 tap_rst_n = 1'b1;

    // reset state
    chk({31'b0, tap_dout_en}, 32'd0, "R3 dout_en low after reset");
    chk({31'b0, cfg_start_n}, 32'd1, "R9 cfg_start_n idle high");
    chk({31'b0, hiz_req},     32'd0, "R8 hiz_req low after reset");
    step(0, 0);

    // default instruction after reset is identification
    dr_scan(32, 32'h1234_5678, ID_V, "R4 R5 IDCODE after reset");

    // status pattern A
    isc_active = 1; rev_done = 1;
    ir_scan(OPC_USERCODE, "R1 R2 capture pattern A");
    dr_scan(32, 32'hFFFF_0000, USER_V, "R5 USERCODE scan");

    // status pattern B
    isc_fail = 1; prog_fail = 1; prog_busy = 1; isc_active = 0; rev_done = 0;
    ir_scan(OPC_BYPASS, "R1 R2 capture pattern B");
    dr_scan(8, 32'hA5, byp_exp(32'hA5, 8), "R6 bypass one-bit delay");
    chk({31'b0, tap_dout_en}, 32'd0, "R3 dout_en low in idle");

    // mixed status, unknown opcode
    isc_fail = 0; prog_busy = 0;
    ir_scan(16'h1234, "R2 capture pattern C");
    dr_scan(8, 32'h3C, byp_exp(32'h3C, 8), "R6 unknown opcode as bypass");

    ir_scan(OPC_HIGHZ, "R1 capture before HIGHZ");
    chk({31'b0, hiz_req},   32'd1, "R8 hiz_req on HIGHZ");
    chk({31'b0, bsr_drive}, 32'd0, "R7 bsr_drive low on HIGHZ");
    dr_scan(4, 32'h9, byp_exp(32'h9, 4), "R6 HIGHZ uses bypass");

    ir_scan(OPC_CLAMP, "R1 capture before CLAMP");
    chk({31'b0, bsr_drive}, 32'd1, "R7 bsr_drive on CLAMP");
    chk({31'b0, bsr_sel},   32'd0, "R7 bsr_sel low on CLAMP");
    chk({31'b0, hiz_req},   32'd0, "R8 hiz_req low on CLAMP");
    dr_scan(4, 32'h6, byp_exp(32'h6, 4), "R6 CLAMP uses bypass");

    bsr_so = 1;
    ir_scan(OPC_EXTEST, "R1 capture before EXTEST");
    chk({31'b0, bsr_sel},   32'd1, "R7 bsr_sel on EXTEST");
    chk({31'b0, bsr_drive}, 32'd1, "R7 bsr_drive on EXTEST");
    dr_scan(6, 32'h0, 32'h3F, "R7 EXTEST routes chain");
    ir_scan(OPC_SAMPLE, "R1 capture before SAMPLE");
    chk({31'b0, bsr_sel},   32'd1, "R7 bsr_sel on SAMPLE");
    chk({31'b0, bsr_drive}, 32'd0, "R7 bsr_drive low on SAMPLE");
    bsr_so = 0;

    // configuration one-shot
    ir_scan(OPC_CONFIG, "R1 capture before CONFIG");
    chk({31'b0, cfg_start_n}, 32'd1, "R9 no pulse on entering idle");
    step(0, 0);
    chk({31'b0, cfg_start_n}, 32'd0, "R9 pulse low in idle");
    chk({31'b0, rev_rst},     32'd1, "R9 rev_rst with pulse");
    step(0, 0);
    chk({31'b0, cfg_start_n}, 32'd1, "R9 pulse one cycle");
    lows = 0;
    for (int i = 0; i < 4; i++) begin step(0, 0); if (!cfg_start_n) lows++; end
    dr_scan(4, 32'h5, byp_exp(32'h5, 4), "R6 CONFIG uses bypass");
    for (int i = 0; i < 4; i++) begin step(0, 0); if (!cfg_start_n) lows++; end
    chk(lows, 32'd0, "R9 no repeat without new update");
    ir_scan(OPC_CONFIG, "R1 capture second CONFIG");
    lows = 0;
    for (int i = 0; i < 5; i++) begin step(0, 0); if (!cfg_start_n) lows++; end
    chk(lows, 32'd1, "R9 second update gives one pulse");

    // reset through five high mode samples
    ir_scan(OPC_USERCODE, "R1 capture before mode reset");
    repeat (5) step(1, 0);
    step(0, 0);
    dr_scan(32, 32'h0, ID_V, "R4 IDCODE after five high mode");

    // reset through the reset pin
    ir_scan(OPC_USERCODE, "R1 capture before pin reset");
    tap_mode = 1'b1;
    @(negedge tap_clk); #3 tap_rst_n = 1'b0;
    repeat (2) @(posedge tap_clk);
    #3 tap_rst_n = 1'b1;
    step(0, 0);
    dr_scan(32, 32'h0, ID_V, "R4 IDCODE after reset pin");

    repeat (4) step(0, 0);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3 scans missing: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule